// File: doc/BRIEF.md
# Mixed-Access Configuration Register Bank

This block holds a few 32-bit configuration and status words behind a simple single-cycle request bus with per-byte enables. Elaboration-time parameter masks give each bit one of six access behaviours:
- a read-only constant;
- a read-only status bit that follows hardware;
- a read-only status bit that latches hardware events and keeps them through a warm reset;
- a read-to-set flag that is cleared by writing 1;
- a plain read/write bit;
- a status bit that events set and software clears by writing 1.

Hardware supplies two flat vectors, one word-slot per register. The status vector feeds the following and the latching status bits. The event vector sets the clearable bits. There are two reset inputs. A warm reset restores every non-latching bit to its default value. A cold reset does the same and also clears the latching bits.

The bus is sampled on every clock edge. When `req_valid` is high, `req_write` selects a write or a read. A read returns the whole addressed word on `rd_data`, one cycle later, with `rd_valid` high for that cycle. The byte enables decide which bytes a write changes and which read-to-set flags a read sets.

Top module: `cfg_regbank`

## Requirements
- R1: Read-only constant bits always read their default value and ignore writes. By default these are register 0 bits [15:0], with value 16'hA5C3.
- R2: Following status bits read the value that the status vector held at the previous clock edge, and they ignore writes. By default these are register 1 bits [7:0], status-vector bits [39:32].
- R3: A latching status bit becomes 1 when its status-vector bit is 1 and stays 1 until a cold reset. It ignores writes and keeps its state through a warm reset. By default these are register 1 bits [15:8], status-vector bits [47:40].
- R4: A byte-enabled read returns the current state of each read-to-set flag in an enabled byte and leaves that flag at 1. As a result, two back-to-back enabled reads return 0 and then 1. By default these are register 2 bits [15:0].
- R5: A read with a flag's byte disabled returns the flag's state and leaves that state unchanged.
- R6: A write of 1 to a read-to-set flag in an enabled byte clears it. A write of 0, or a write with the byte disabled, leaves it unchanged.
- R7: Read/write bits take the write data only in enabled bytes of a write to their register. Nothing else changes them except reset. By default these are register 0 bits [31:16] with default 16'h1234, register 2 bits [31:16] with default 0, and register 3 with default 32'hDEADBEEF.
- R8: A clearable status bit is set by a 1 on its event-vector bit. A write of 1 in an enabled byte clears it. A write of 0 or a disabled byte has no effect. By default these are register 1 bits [31:16], event-vector bits [63:48].
- R9: When an event and a write-1 clear reach the same clearable bit in one cycle, the bit ends up set.
- R10: A read accepted at one edge drives `rd_valid` high, with the addressed word on `rd_data`, for the following cycle only. Writes and idle cycles leave `rd_valid` low.
- R11: Either reset returns every non-latching bit to its default value and drops `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| warm_rst | input | 1 | Synchronous warm reset, active high; latching bits keep their state |
| cold_rst | input | 1 | Synchronous cold reset, active high; resets every bit |
| req_valid | input | 1 | A bus request is present this cycle |
| req_write | input | 1 | 1 selects a write, 0 selects a read |
| req_addr | input | ADDR_W | Register index |
| req_be | input | 4 | Byte enables, bit n covers data bits [8n+7:8n] |
| req_wdata | input | 32 | Write data |
| hw_stat | input | NREG*32 | Status inputs, word-slot per register |
| hw_set | input | NREG*32 | Set events for the clearable bits, word-slot per register |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Registered read data |

## Verification
The bench builds the bank with its default parameters: four registers and a 2-bit address. Under these defaults every access behaviour appears in at least one register, and register 1 mixes following, latching and clearable bits in a single word. This layout makes it possible to check per-byte enables against each behaviour, the order in which back-to-back flag reads return values, and the difference between the two resets on one readback. It also makes it possible to drive an event and a clearing write into the same cycle.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned BE_W   = WORD_W / 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BE_W-1:0]   be_t;

    // Per-register strobes produced by the decoder
    typedef struct packed {
        logic  rd;
        logic  wr;
        word_t bmask;
        word_t wdata;
    } reg_access_t;

    function automatic word_t lane_mask(be_t be);
        word_t m;
        for (int i = 0; i < int'(BE_W); i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic word_t byte_merge(word_t old_v, word_t new_v, word_t m);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/cfg_bus_decode.sv
module cfg_bus_decode
    import cfg_regbank_pkg::*;
#(
    parameter int unsigned NREG   = 4,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  be_t               req_be,
    input  word_t             req_wdata,
    output reg_access_t       acc [NREG]
);

    word_t bm;
    assign bm = lane_mask(req_be);

    for (genvar r = 0; r < int'(NREG); r++) begin : g_dec
        logic hit;
        assign hit        = req_valid && (int'(req_addr) == r);
        assign acc[r].rd    = hit && !req_write;
        assign acc[r].wr    = hit &&  req_write;
        assign acc[r].bmask = bm;
        assign acc[r].wdata = req_wdata;
    end

endmodule

// File: rtl/cfg_reg_word.sv
module cfg_reg_word
    import cfg_regbank_pkg::*;
#(
    parameter word_t M_RO   = '0,
    parameter word_t M_ROV  = '0,
    parameter word_t M_STK  = '0,
    parameter word_t M_AF   = '0,
    parameter word_t M_RW   = '0,
    parameter word_t M_W1C  = '0,
    parameter word_t DFLT   = '0
) (
    input  logic        clk,
    input  logic        warm_rst,
    input  logic        cold_rst,
    input  reg_access_t acc,
    input  word_t       stat_in,
    input  word_t       set_in,
    output word_t       value
);

    localparam word_t M_PLAIN = ~M_STK;

    word_t plain_q, plain_d;
    word_t stk_q;
    word_t wr_ones;
    word_t rw_nxt, w1c_nxt, af_nxt;

    // ones being written into enabled bytes
    assign wr_ones = acc.wr ? (acc.wdata & acc.bmask) : '0;

    always_comb begin
        rw_nxt  = acc.wr ? byte_merge(plain_q, acc.wdata, acc.bmask) : plain_q;
        // event set is applied after the clear: set wins
        w1c_nxt = (plain_q & ~wr_ones) | set_in;
        if (acc.rd)
            af_nxt = plain_q | acc.bmask;
        else
            af_nxt = plain_q & ~wr_ones;
        plain_d = (M_RO  & DFLT)
                | (M_ROV & stat_in)
                | (M_RW  & rw_nxt)
                | (M_W1C & w1c_nxt)
                | (M_AF  & af_nxt);
    end

    always_ff @(posedge clk) begin
        if (warm_rst || cold_rst)
            plain_q <= DFLT & M_PLAIN;
        else
            plain_q <= plain_d & M_PLAIN;
    end

    always_ff @(posedge clk) begin
        if (cold_rst)
            stk_q <= DFLT & M_STK;
        else
            stk_q <= (stk_q | stat_in) & M_STK;
    end

    assign value = (plain_q & M_PLAIN) | (stk_q & M_STK);

endmodule

// File: rtl/cfg_rd_port.sv
module cfg_rd_port
    import cfg_regbank_pkg::*;
#(
    parameter int unsigned NREG   = 4,
    parameter int unsigned ADDR_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_req,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [NREG*WORD_W-1:0] words,
    output logic                   rd_valid,
    output word_t                  rd_data
);

    word_t sel;
    always_comb begin
        sel = '0;
        for (int r = 0; r < int'(NREG); r++) begin
            if (int'(rd_addr) == r) sel = words[r*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= sel;
        end
    end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_regbank_pkg::*;
#(
    parameter int unsigned NREG   = 4,
    parameter int unsigned ADDR_W = 2,
    // masks and defaults, register 0 in the low word
    parameter logic [NREG*32-1:0] P_RO  = {32'h0, 32'h0, 32'h0, 32'h0000_FFFF},
    parameter logic [NREG*32-1:0] P_ROV = {32'h0, 32'h0, 32'h0000_00FF, 32'h0},
    parameter logic [NREG*32-1:0] P_STK = {32'h0, 32'h0, 32'h0000_FF00, 32'h0},
    parameter logic [NREG*32-1:0] P_AF  = {32'h0, 32'h0000_FFFF, 32'h0, 32'h0},
    parameter logic [NREG*32-1:0] P_RW  = {32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0, 32'hFFFF_0000},
    parameter logic [NREG*32-1:0] P_W1C = {32'h0, 32'h0, 32'hFFFF_0000, 32'h0},
    parameter logic [NREG*32-1:0] P_DEF = {32'hDEAD_BEEF, 32'h0, 32'h0, 32'h1234_A5C3}
) (
    input  logic                 clk,
    input  logic                 warm_rst,
    input  logic                 cold_rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [3:0]           req_be,
    input  logic [31:0]          req_wdata,
    input  logic [NREG*32-1:0]   hw_stat,
    input  logic [NREG*32-1:0]   hw_set,
    output logic                 rd_valid,
    output logic [31:0]          rd_data
);

    localparam int unsigned FLAT_W = NREG * WORD_W;

    reg_access_t        acc [NREG];
    logic [FLAT_W-1:0]  word_flat;

    cfg_bus_decode #(.NREG(NREG), .ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .acc       (acc)
    );

    for (genvar r = 0; r < int'(NREG); r++) begin : g_word
        cfg_reg_word #(
            .M_RO  (P_RO [r*32 +: 32]),
            .M_ROV (P_ROV[r*32 +: 32]),
            .M_STK (P_STK[r*32 +: 32]),
            .M_AF  (P_AF [r*32 +: 32]),
            .M_RW  (P_RW [r*32 +: 32]),
            .M_W1C (P_W1C[r*32 +: 32]),
            .DFLT  (P_DEF[r*32 +: 32])
        ) u_word (
            .clk      (clk),
            .warm_rst (warm_rst),
            .cold_rst (cold_rst),
            .acc      (acc[r]),
            .stat_in  (hw_stat[r*32 +: 32]),
            .set_in   (hw_set[r*32 +: 32]),
            .value    (word_flat[r*32 +: 32])
        );
    end

    cfg_rd_port #(.NREG(NREG), .ADDR_W(ADDR_W)) u_rd (
        .clk      (clk),
        .rst      (warm_rst || cold_rst),
        .rd_req   (req_valid && !req_write),
        .rd_addr  (req_addr),
        .words    (word_flat),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
    parameter int unsigned NREG   = 4,
    parameter int unsigned ADDR_W = 2,
    parameter logic [NREG*32-1:0] P_RO  = '0,
    parameter logic [NREG*32-1:0] P_STK = '0,
    parameter logic [NREG*32-1:0] P_AF  = '0,
    parameter logic [NREG*32-1:0] P_RW  = '0,
    parameter logic [NREG*32-1:0] P_W1C = '0,
    parameter logic [NREG*32-1:0] P_DEF = '0
) (
    input logic                 clk,
    input logic                 warm_rst,
    input logic                 cold_rst,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [3:0]           req_be,
    input logic [NREG*32-1:0]   hw_set,
    input logic [NREG*32-1:0]   word_flat,
    input logic                 rd_valid,
    input logic [31:0]          rd_data
);

    logic                rst_any;
    logic [ADDR_W-1:0]   last_addr;
    logic [31:0]         ro_m, def_w;
    logic [NREG*32-1:0]  af_touch, w1c_ev, stk_prev;
    logic                armed1, armed;

    assign rst_any = warm_rst || cold_rst;

    always_ff @(posedge clk) begin
        if (req_valid && !req_write) last_addr <= req_addr;
    end

    always_comb begin
        ro_m  = '0;
        def_w = '0;
        af_touch = '0;
        for (int r = 0; r < int'(NREG); r++) begin
            if (int'(last_addr) == r) begin
                ro_m  = P_RO [r*32 +: 32];
                def_w = P_DEF[r*32 +: 32];
            end
            if (req_valid && !req_write && int'(req_addr) == r)
                af_touch[r*32 +: 32] = P_AF[r*32 +: 32] &
                    {{8{req_be[3]}}, {8{req_be[2]}}, {8{req_be[1]}}, {8{req_be[0]}}};
        end
    end

    assign w1c_ev = hw_set & P_W1C;

    always_ff @(posedge clk) begin
        armed1   <= !cold_rst;
        armed    <= armed1 && !cold_rst;
        stk_prev <= word_flat & P_STK;
    end

    assert_rd_valid_R10: assert property (@(posedge clk) disable iff (rst_any)
        (req_valid && !req_write) |=> rd_valid);

    assert_no_rd_valid_R10: assert property (@(posedge clk) disable iff (rst_any)
        !(req_valid && !req_write) |=> !rd_valid);

    assert_ro_const_R1: assert property (@(posedge clk) disable iff (rst_any)
        rd_valid |-> (((rd_data ^ def_w) & ro_m) == '0));

    assert_af_set_R4: assert property (@(posedge clk) disable iff (rst_any)
        (af_touch != '0) |=> ((word_flat & $past(af_touch)) == $past(af_touch)));

    assert_w1c_set_wins_R9: assert property (@(posedge clk) disable iff (rst_any)
        (w1c_ev != '0) |=> ((word_flat & $past(w1c_ev)) == $past(w1c_ev)));

    assert_rw_stable_R7: assert property (@(posedge clk) disable iff (rst_any)
        !(req_valid && req_write) |=> $stable(word_flat & P_RW));

    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (cold_rst)
        armed |-> ((stk_prev & ~word_flat) == '0));

endmodule

bind cfg_regbank cfg_regbank_chk #(
    .NREG(NREG), .ADDR_W(ADDR_W),
    .P_RO(P_RO), .P_STK(P_STK), .P_AF(P_AF),
    .P_RW(P_RW), .P_W1C(P_W1C), .P_DEF(P_DEF)
) u_chk (
    .clk       (clk),
    .warm_rst  (warm_rst),
    .cold_rst  (cold_rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .hw_set    (hw_set),
    .word_flat (word_flat),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
);

// File: tb/cfg_regbank_tb_top.sv
module cfg_regbank_tb_top;

    logic         clk = 1'b0;
    logic         warm_rst = 1'b0;
    logic         cold_rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [1:0]   req_addr = '0;
    logic [3:0]   req_be = '0;
    logic [31:0]  req_wdata = '0;
    logic [127:0] hw_stat = '0;
    logic [127:0] hw_set = '0;
    logic         rd_valid;
    logic [31:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cfg_regbank dut_i (
        .clk (clk), .warm_rst (warm_rst), .cold_rst (cold_rst),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_be (req_be), .req_wdata (req_wdata),
        .hw_stat (hw_stat), .hw_set (hw_set),
        .rd_valid (rd_valid), .rd_data (rd_data)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        {1'b0, 2'd0, 4'hF, 32'h0,         32'h1234_A5C3},  // R11 default
        {1'b1, 2'd0, 4'hF, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 2'd0, 4'hF, 32'h0,         32'hFFFF_A5C3},  // R1 R7
        {1'b1, 2'd0, 4'h4, 32'h0,         32'h0},
        {1'b0, 2'd0, 4'hF, 32'h0,         32'hFF00_A5C3},  // R7 byte enable
        {1'b1, 2'd3, 4'h3, 32'h0000_1111, 32'h0},
        {1'b0, 2'd3, 4'hF, 32'h0,         32'hDEAD_1111},  // R7
        {1'b0, 2'd2, 4'h1, 32'h0,         32'h0},          // R4 first read
        {1'b0, 2'd2, 4'hF, 32'h0,         32'h0000_00FF},  // R4
        {1'b0, 2'd2, 4'hF, 32'h0,         32'h0000_FFFF},  // R4
        {1'b1, 2'd2, 4'h2, 32'h0000_0F00, 32'h0},
        {1'b0, 2'd2, 4'h2, 32'h0,         32'h0000_F0FF},  // R6 clear
        {1'b0, 2'd2, 4'hF, 32'h0,         32'h0000_FFFF},  // R4
        {1'b1, 2'd2, 4'hF, 32'hABCD_0000, 32'h0},
        {1'b0, 2'd2, 4'h0, 32'h0,         32'hABCD_FFFF},  // R5 R6 R7
        {1'b0, 2'd1, 4'hF, 32'h0,         32'h0}           // R11
    };

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] a, input logic [3:0] be,
                          input logic [31:0] d, output logic [31:0] got, output logic gv);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        got = rd_data; gv = rd_valid;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [3:0] be,
                      input logic [31:0] exp, input string tag);
        logic [31:0] g; logic v;
        access(1'b0, a, be, 32'h0, g, v);
        chk(v === 1'b1, {tag, " R10 valid"}, {31'h0, v}, 32'h1);
        chk(g === exp, tag, g, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] g; logic v;
        access(1'b1, a, be, d, g, v);
        chk(v === 1'b0, "R10 no valid on write", {31'h0, v}, 32'h0);
    endtask

    task automatic pulse_rst(input bit cold);
        if (cold) cold_rst = 1'b1; else warm_rst = 1'b1;
        @(negedge clk);
        cold_rst = 1'b0; warm_rst = 1'b0;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        cold_rst = 1'b0;
        chk(rd_valid === 1'b0, "R11 rd_valid after reset", {31'h0, rd_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VT[i].wr) wr(VT[i].addr, VT[i].be, VT[i].data);
            else          rd(VT[i].addr, VT[i].be, VT[i].exp, $sformatf("vector %0d", i));
        end

        // read-to-set flags and byte enables
        pulse_rst(1'b1);
        rd(2'd2, 4'hC, 32'h0, "R5 disabled-byte read");
        rd(2'd2, 4'h1, 32'h0, "R5 state kept, R4 first read");
        rd(2'd2, 4'h1, 32'h0000_00FF, "R4 back-to-back second read");
        wr(2'd2, 4'hF, 32'h0);
        rd(2'd2, 4'h2, 32'h0000_00FF, "R6 write zero no effect");
        wr(2'd2, 4'hE, 32'h0000_00FF);
        rd(2'd2, 4'h0, 32'h0000_FFFF, "R6 disabled byte no clear");
        wr(2'd2, 4'h1, 32'h0000_00FF);
        rd(2'd2, 4'h0, 32'h0000_FF00, "R6 enabled clear");

        // following and latching status
        hw_stat[63:32] = 32'h0000_025A;
        @(negedge clk);
        rd(2'd1, 4'hF, 32'h0000_025A, "R2 R3 status capture");
        hw_stat = '0;
        @(negedge clk);
        rd(2'd1, 4'hF, 32'h0000_0200, "R2 follows, R3 latched");
        wr(2'd1, 4'hF, 32'hFFFF_FFFF);
        rd(2'd1, 4'hF, 32'h0000_0200, "R2 R3 R8 write ignored");
        wr(2'd0, 4'hF, 32'h0);
        pulse_rst(1'b0);
        rd(2'd1, 4'hF, 32'h0000_0200, "R3 survives warm reset");
        rd(2'd0, 4'hF, 32'h1234_A5C3, "R11 warm reset default");
        pulse_rst(1'b1);
        rd(2'd1, 4'hF, 32'h0, "R3 cold reset clears");

        // clearable status
        hw_set[63:32] = 32'h0003_0000;
        @(negedge clk);
        hw_set = '0;
        rd(2'd1, 4'hF, 32'h0003_0000, "R8 event sets");
        wr(2'd1, 4'h4, 32'h0001_0000);
        rd(2'd1, 4'hF, 32'h0002_0000, "R8 write one clears");
        wr(2'd1, 4'hF, 32'h0);
        wr(2'd1, 4'hB, 32'h0002_0000);
        rd(2'd1, 4'hF, 32'h0002_0000, "R8 zero or disabled byte");
        hw_set[63:32] = 32'h0001_0000;
        wr(2'd1, 4'hF, 32'h0003_0000);
        hw_set = '0;
        rd(2'd1, 4'hF, 32'h0001_0000, "R9 set wins over clear");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule